// File: doc/BRIEF.md
# I2C Serial Clock Divider with Command Strobe

This block produces the serial clock for an I2C controller from a prescaled input clock. Software programs an 8-bit divider value through a small register port. The half-period of the generated clock is that value plus a fixed offset of 3, and 2 more cycles are added when the input glitch filter is switched on. The result is a clock with exactly equal high and low phases. Divider values that are too small for the selected filter setting are raised to the smallest legal value, and a status output reports that this has happened.

A second register holds a master/slave select bit and a start bit that clears itself. Writing the start bit sends a one-cycle pulse to the protocol engine. In master mode it is a transmit request. In slave mode it arms the transmitter, but only while the engine reports that it is idle. Alongside the clock, the block gives a one-cycle tick on every low-to-high transition of the serial clock, for the engine to use as a clock enable. While the run input is low, the clock rests at the high level, which is the bus idle level.

Top module: `i2c_sclk_gen`

## Requirements
- R1: The high phase and the low phase of `sclk` each last H = D + 3 + 2·F input clock cycles. D is the effective divider value written at register select 0, and F is `filt_en`.
- R2: After reset, register select 0 reads 8'hFF, register select 1 reads 8'h00, `sclk` is high, and `start_mst`, `start_slv` and `sclk_rise` are low.
- R3: A stored divider below 3 (F=0), or below 6 (F=1), is treated as that minimum. `div_clamped` is high exactly while the stored divider is below the minimum for the current `filt_en`.
- R4: A new divider or filter value has no effect on the phase in progress. It is taken up at the next low-to-high transition of `sclk`.
- R5: While `run_en` is low, `sclk` is held high and the phase counter is cleared. The first falling edge comes H clock edges after `run_en` is first sampled high.
- R6: `sclk_rise` is high for exactly the one cycle in which `sclk` has just changed from low to high, and is low in every other cycle.
- R7: A write to select 1 with bit 7 = 1 and bit 0 = 1 (master) raises `start_mst` for exactly one cycle, in the cycle after the write.
- R8: A write to select 1 with bit 7 = 1 and bit 0 = 0 (slave) raises `start_slv` for one cycle if `eng_idle` is high. If `eng_idle` is low, the write gives no pulse. Neither case raises `start_mst`.
- R9: Register select 1 reads bit 0 as the stored master/slave bit (1 = master) and bit 7 always as 0. `master_mode` follows bit 0. A command write with bit 7 = 0 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled input clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = divider register, 1 = command register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the selected register |
| filt_en | input | 1 | Input filter enable; adds 2 to the half-period |
| run_en | input | 1 | Clock run enable; low holds `sclk` high |
| eng_idle | input | 1 | Protocol engine idle indication |
| sclk | output | 1 | Generated serial clock |
| sclk_rise | output | 1 | One-cycle tick on each rising transition of `sclk` |
| start_mst | output | 1 | Master transmit start pulse |
| start_slv | output | 1 | Slave transmitter arm pulse |
| master_mode | output | 1 | Stored master/slave select |
| div_clamped | output | 1 | Stored divider is below the legal minimum |

## Verification
The hardest condition to create is a settings change that lands in the middle of a running phase. Only then does it show that the phase in progress keeps its old length and the next period takes up the new one. The bench tracks the run length of every high and low phase at the ports. It writes the new divider in the cycle right after a detected rising edge. It then checks the period that follows the write against the old half-period, and the period after that against the new half-period. Clamping is reached by writing divider values below each of the two minimums. The filter input is toggled while the clock runs.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
   localparam int unsigned MIN_DIV_PLAIN = 3;
   localparam int unsigned MIN_DIV_FILT  = 6;
   localparam int unsigned HALF_OFFS     = 3;
   localparam int unsigned FILT_OFFS     = 2;
   localparam int unsigned CMD_START_BIT = 7;
   localparam int unsigned CMD_MODE_BIT  = 0;

   typedef enum logic [0:0] {
      SEL_DIV = 1'b0,
      SEL_CMD = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/sclk_regs.sv
module sclk_regs
   import sclk_gen_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic          sel,
   input  logic [DW-1:0] wdata,
   input  logic          eng_idle,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] div_q,
   output logic          master_q,
   output logic          start_mst,
   output logic          start_slv
);
   logic cmd_wr;
   assign cmd_wr = wr && (sel == SEL_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '1;
         master_q  <= 1'b0;
         start_mst <= 1'b0;
         start_slv <= 1'b0;
      end else begin
         start_mst <= 1'b0;
         start_slv <= 1'b0;
         if (wr && (sel == SEL_DIV)) begin
            div_q <= wdata;
         end
         if (cmd_wr) begin
            master_q <= wdata[CMD_MODE_BIT];
            if (wdata[CMD_START_BIT]) begin
               if (wdata[CMD_MODE_BIT]) begin
                  start_mst <= 1'b1;
               end else if (eng_idle) begin
                  start_slv <= 1'b1;
               end
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel == SEL_DIV) begin
         rdata = div_q;
      end else begin
         rdata[CMD_MODE_BIT] = master_q;
      end
   end

   a_r7_mst_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      start_mst |-> $past(cmd_wr && wdata[CMD_START_BIT] && wdata[CMD_MODE_BIT]));
   a_r8_slv_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_slv |-> $past(eng_idle && cmd_wr && !wdata[CMD_MODE_BIT]));
   a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_mst && start_slv));
endmodule

// File: rtl/sclk_half_calc.sv
module sclk_half_calc
   import sclk_gen_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter bit          CLAMP_EN = 1'b1,
   localparam int unsigned HW     = DW + 2
) (
   input  logic [DW-1:0] div,
   input  logic          filt,
   output logic [HW-1:0] half,
   output logic          clamped
);
   logic [HW-1:0] div_eff;
   logic [HW-1:0] extra;

   assign extra = filt ? HW'(HALF_OFFS + FILT_OFFS) : HW'(HALF_OFFS);

   generate
      if (CLAMP_EN) begin : g_clamp
         logic [DW-1:0] min_div;
         assign min_div = filt ? DW'(MIN_DIV_FILT) : DW'(MIN_DIV_PLAIN);
         assign clamped = (div < min_div);
         assign div_eff = clamped ? HW'(min_div) : HW'(div);
      end else begin : g_raw
         assign clamped = 1'b0;
         assign div_eff = HW'(div);
      end
   endgenerate

   assign half = div_eff + extra;
endmodule

// File: rtl/sclk_phase_ctr.sv
module sclk_phase_ctr #(
   parameter int unsigned HW       = 10,
   parameter int unsigned HALF_RST = 258,
   parameter int unsigned MIN_HALF = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic [HW-1:0] half_live,
   output logic          sclk,
   output logic          rise
);
   logic [HW-1:0] cnt;
   logic [HW-1:0] half_lat;
   logic          phase_end;

   assign phase_end = (cnt == half_lat - HW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sclk     <= 1'b1;
         rise     <= 1'b0;
         half_lat <= HW'(HALF_RST);
      end else if (!run_en) begin
         cnt      <= '0;
         sclk     <= 1'b1;
         rise     <= !sclk;
         half_lat <= half_live;
      end else if (phase_end) begin
         cnt  <= '0;
         sclk <= !sclk;
         rise <= !sclk;
         if (!sclk) begin
            half_lat <= half_live;
         end
      end else begin
         cnt  <= cnt + HW'(1);
         rise <= 1'b0;
      end
   end

   a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < half_lat);
   a_r3_half_floor: assert property (@(posedge clk) disable iff (!rst_n)
      half_lat >= HW'(MIN_HALF));
   a_r4_latch_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(half_lat) |-> (rise || !$past(run_en)));
   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> sclk);
   a_r6_rise_means_high: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (sclk && !$past(sclk)));
   a_r6_edge_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && !$past(sclk)) |-> rise);
endmodule

// File: rtl/i2c_sclk_gen.sv
module i2c_sclk_gen
   import sclk_gen_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter bit          CLAMP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          filt_en,
   input  logic          run_en,
   input  logic          eng_idle,
   output logic          sclk,
   output logic          sclk_rise,
   output logic          start_mst,
   output logic          start_slv,
   output logic          master_mode,
   output logic          div_clamped
);
   localparam int unsigned HW       = DW + 2;
   localparam int unsigned HALF_RST = (2 ** DW - 1) + HALF_OFFS;
   localparam int unsigned MIN_HALF = CLAMP_EN ? (MIN_DIV_PLAIN + HALF_OFFS) : HALF_OFFS;

   generate
      if (DW < 8 || DW > 16) begin : g_bad_dw
         $error("i2c_sclk_gen: DW must lie in 8..16");
      end
   endgenerate

   logic [DW-1:0] div_q;
   logic [HW-1:0] half_live;

   sclk_regs #(.DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .sel       (reg_sel),
      .wdata     (reg_wdata),
      .eng_idle  (eng_idle),
      .rdata     (reg_rdata),
      .div_q     (div_q),
      .master_q  (master_mode),
      .start_mst (start_mst),
      .start_slv (start_slv)
   );

   sclk_half_calc #(.DW(DW), .CLAMP_EN(CLAMP_EN)) u_calc (
      .div     (div_q),
      .filt    (filt_en),
      .half    (half_live),
      .clamped (div_clamped)
   );

   sclk_phase_ctr #(.HW(HW), .HALF_RST(HALF_RST), .MIN_HALF(MIN_HALF)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .half_live (half_live),
      .sclk      (sclk),
      .rise      (sclk_rise)
   );
endmodule

// File: tb/test_i2c_sclk_gen.sv
module test_i2c_sclk_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       filt_en = 1'b0;
   logic       run_en = 1'b0;
   logic       eng_idle = 1'b0;
   logic       sclk, sclk_rise, start_mst, start_slv, master_mode, div_clamped;

   int n_chk = 0;
   int n_fail = 0;
   int n_rise = 0;
   int run_len = 0;
   int last_hi = 0;
   int last_lo = 0;
   int rise_err = 0;
   logic prev = 1'b1;

   always #10 clk = !clk;

   i2c_sclk_gen i_i2c_sclk_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .filt_en(filt_en),
      .run_en(run_en), .eng_idle(eng_idle), .sclk(sclk), .sclk_rise(sclk_rise),
      .start_mst(start_mst), .start_slv(start_slv), .master_mode(master_mode),
      .div_clamped(div_clamped)
   );

   // phase tracker: run lengths and rise tick checking, sampled at negedge
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk_rise !== (sclk && !prev)) rise_err++;
         if (sclk != prev) begin
            if (prev) last_hi = run_len;
            else      last_lo = run_len;
            if (sclk) n_rise++;
            run_len = 1;
         end else begin
            run_len++;
         end
         prev = sclk;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic wr_reg(input logic sel, input logic [7:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wait_rises(input int k);
      int target;
      target = n_rise + k;
      while (n_rise < target) @(posedge clk);
   endtask

   task automatic expect_period(input int h, input string req);
      wait_rises(2);
      check(last_hi == h, req, last_hi, h);
      check(last_lo == h, req, last_lo, h);
   endtask

   task automatic t_reset();
      @(negedge clk);
      reg_sel = 1'b0; #1;
      check(reg_rdata == 8'hFF, "R2 div reset", reg_rdata, 8'hFF);
      reg_sel = 1'b1; #1;
      check(reg_rdata == 8'h00, "R2 cmd reset", reg_rdata, 0);
      check(sclk == 1'b1, "R2 sclk idle", sclk, 1);
      check({start_mst, start_slv, sclk_rise} == 3'b000, "R2 pulses low",
            {start_mst, start_slv, sclk_rise}, 0);
   endtask

   task automatic t_basic_period();
      wr_reg(1'b0, 8'd5);
      check(div_clamped == 1'b0, "R3 no clamp at 5", div_clamped, 0);
      run_en = 1'b1;
      expect_period(8, "R1 div5 plain");
   endtask

   task automatic t_filter_and_clamp();
      filt_en = 1'b1; #1;
      check(div_clamped == 1'b1, "R3 flag 5 filt", div_clamped, 1);
      expect_period(11, "R3 clamp to 6 with filter");
      wr_reg(1'b0, 8'd8);
      check(div_clamped == 1'b0, "R3 flag 8 filt", div_clamped, 0);
      expect_period(13, "R1 div8 filt");
      filt_en = 1'b0;
      wr_reg(1'b0, 8'd1);
      check(div_clamped == 1'b1, "R3 flag 1 plain", div_clamped, 1);
      expect_period(6, "R3 clamp to 3 plain");
   endtask

   task automatic t_update_at_rise();
      wr_reg(1'b0, 8'd5);
      wait_rises(2);
      wr_reg(1'b0, 8'd10);
      wait_rises(1);
      check(last_hi == 8, "R4 old high kept", last_hi, 8);
      check(last_lo == 8, "R4 old low kept", last_lo, 8);
      wait_rises(1);
      check(last_hi == 13, "R4 new high", last_hi, 13);
      check(last_lo == 13, "R4 new low", last_lo, 13);
   endtask

   task automatic t_idle();
      int hi_cnt;
      bit held;
      @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
      held = 1'b1;
      for (int i = 0; i < 30; i++) begin
         if (sclk !== 1'b1) held = 1'b0;
         @(negedge clk);
      end
      check(held, "R5 held high while disabled", held, 1);
      wr_reg(1'b0, 8'd4);
      @(negedge clk);
      run_en = 1'b1;
      hi_cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (sclk == 1'b0) break;
         hi_cnt++;
      end
      check(hi_cnt == 6, "R5 first fall after enable", hi_cnt + 1, 7);
      expect_period(7, "R1 div4 plain");
   endtask

   task automatic t_rise_tick();
      check(rise_err == 0, "R6 rise tick mismatches", rise_err, 0);
   endtask

   task automatic t_master_start();
      wr_reg(1'b1, 8'h81);
      check(start_mst == 1'b1, "R7 master pulse", start_mst, 1);
      check(start_slv == 1'b0, "R7 no slave pulse", start_slv, 0);
      @(negedge clk);
      check(start_mst == 1'b0, "R7 pulse one cycle", start_mst, 0);
      reg_sel = 1'b1; #1;
      check(reg_rdata == 8'h01, "R9 readback start zero", reg_rdata, 8'h01);
      check(master_mode == 1'b1, "R9 master_mode", master_mode, 1);
      wr_reg(1'b1, 8'h01);
      check(start_mst == 1'b0, "R9 no pulse without start", start_mst, 0);
   endtask

   task automatic t_slave_start();
      eng_idle = 1'b0;
      wr_reg(1'b1, 8'h80);
      check({start_mst, start_slv} == 2'b00, "R8 busy ignored", {start_mst, start_slv}, 0);
      @(negedge clk);
      check({start_mst, start_slv} == 2'b00, "R8 busy ignored later", {start_mst, start_slv}, 0);
      check(master_mode == 1'b0, "R9 slave mode stored", master_mode, 0);
      eng_idle = 1'b1;
      wr_reg(1'b1, 8'h80);
      check(start_slv == 1'b1, "R8 slave arm pulse", start_slv, 1);
      check(start_mst == 1'b0, "R8 no master pulse", start_mst, 0);
      @(negedge clk);
      check(start_slv == 1'b0, "R8 pulse one cycle", start_slv, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic_period();
      t_filter_and_clamp();
      t_update_at_rise();
      t_idle();
      t_rise_tick();
      t_master_start();
      t_slave_start();
      repeat (4) @(negedge clk);
      finish_up();
   end
endmodule